// File: doc/BRIEF.md
# Block Write-Protection Lock Manager

This block holds the write-protection state of every erase block of a flash array. Each block is in one of three states: open for writing, locked, or locked-tight. A locked-tight block cannot be opened or relocked again until the next cold reset. Software loads a start and an end block index through a small register port. It then issues one of four sweep commands: open a range, lock a range, open every block, or lock a range tight. The sweep visits one block per clock and raises a completion pulse and a sticky interrupt flag when it ends.

A program or erase engine beside the block reads one block's state at a time through a combinational query port. The last state the sweep wrote is held in a status register. The block count is a parameter and need not be a power of two. Indices are carried in the narrowest field that covers the count. A sweep that runs onto an index at or beyond the count stops there and raises a command-error flag.

Top module: `wp_lock_mgr`

## Requirements
- R1: State codes are one-hot: locked-tight = 3'b001, locked = 3'b010, open = 3'b100. After reset every block reads locked, `wp_status` is 3'b010 (value 2), and `busy`, `done`, `int_flag` and `cmd_err` are low.
- R2: A write with `reg_sel`=0 stores `reg_wdata` masked to AW bits (AW = clog2(NBLK)) as the start index and copies it into the end index. A write with `reg_sel`=1 replaces only the end index.
- R3: A write with `reg_sel`=2 issues a command. Code 8'h11 opens a range and code 8'h21 locks a range. The range runs from start to end inclusive, and one block is written on each clock that `busy` is high. A sweep that visits n blocks keeps `busy` high for exactly n cycles.
- R4: An open-range, lock-range or open-all sweep ends at the first block it finds locked-tight. That block and every later block stay unchanged. A locked-tight block keeps that state until reset.
- R5: Code 8'h31 locks a range tight. It steps over blocks that are open, leaving them open, and makes every other block in the range locked-tight.
- R6: Code 8'h12 opens every block from 0 up to NBLK-1, subject to R4.
- R7: When a range sweep reaches an index at or above NBLK, it sets `cmd_err` and ends. Blocks before that index are already updated. That index uses one busy cycle.
- R8: If start is greater than end, a range command changes no block and ends after one busy cycle.
- R9: `wp_status` takes the state code of each block the sweep writes. A sweep that writes no block leaves it unchanged.
- R10: When a sweep ends, `busy` falls, `done` is high for one cycle and `int_flag` is set. A write with `reg_sel`=3 clears both `int_flag` and `cmd_err`.
- R11: Register writes are ignored while `busy` is high. A command code outside the four listed above is ignored: it does not raise `busy` and does not set `int_flag`.
- R12: `q_state` shows the state of block `q_blk` in the same cycle. For `q_blk` >= NBLK it shows 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 start index, 1 end index, 2 command, 3 clear flags |
| reg_wdata | input | DW | Write data |
| q_blk | input | AW | Block index for the query port |
| q_state | output | 3 | State of the queried block |
| start_idx | output | AW | Current start index |
| end_idx | output | AW | Current end index |
| wp_status | output | 3 | Last state code written by a sweep |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse when a sweep ends |
| int_flag | output | 1 | Sticky completion interrupt |
| cmd_err | output | 1 | Sticky out-of-range error |

## Verification
The bench drives every start/end pair of a 12-block array, with indices 12 to 15 out of range. It runs each pair through range opens and locks, and through tight-locks over a mixed open/locked/tight map. A design that treated the tight-lock sweep like the others would stop at the first open block instead of stepping over it. A design that let an open or lock sweep step past a tight block would overwrite later blocks. The bench counts busy cycles against the number of blocks visited. A sweep that is one cycle short or long, that skips the inclusive end, or that does not stop at the first out-of-range index shows up in that count or in `cmd_err`. Writes made during a sweep and unknown command codes are checked to leave the index registers, `busy` and the interrupt untouched.

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr #(
  parameter int NBLK = 12,
  parameter int DW   = 16,
  localparam int AW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic [AW-1:0] q_blk,
  output logic [2:0]    q_state,
  output logic [AW-1:0] start_idx,
  output logic [AW-1:0] end_idx,
  output logic [2:0]    wp_status,
  output logic          busy,
  output logic          done,
  output logic          int_flag,
  output logic          cmd_err
);
  localparam int NSLOT = 1 << AW;
  localparam logic [2:0] S_TIGHT = 3'b001, S_LOCK = 3'b010, S_OPEN = 3'b100;
  localparam logic [7:0] C_OPEN = 8'h11, C_ALL = 8'h12, C_LOCK = 8'h21, C_TIGHT = 8'h31;

  typedef enum logic [1:0] {M_OPEN, M_LOCK, M_TIGHT} mode_t;

  logic [2:0]    st [NSLOT];
  logic [AW-1:0] idx, hi;
  mode_t         mode;

  wire [7:0] code   = reg_wdata[7:0];
  wire       known  = (code == C_OPEN) || (code == C_ALL) || (code == C_LOCK) || (code == C_TIGHT);
  wire       in_rng = 32'(idx) < NBLK;
  wire [2:0] cur    = in_rng ? st[idx] : S_LOCK;
  wire [2:0] tgt    = (mode == M_OPEN) ? S_OPEN : (mode == M_LOCK) ? S_LOCK : S_TIGHT;
  wire       over   = idx > hi;
  wire       halt   = (mode != M_TIGHT) && (cur == S_TIGHT);
  wire       skip   = (mode == M_TIGHT) && (cur == S_OPEN);
  wire       wr_en  = busy && !over && in_rng && !halt && !skip;
  wire       err_hit = busy && !over && !in_rng;
  wire       fin    = over || !in_rng || halt || (idx == hi);

  assign q_state = (32'(q_blk) < NBLK) ? st[q_blk] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) st[i] <= S_LOCK;
      idx <= '0;
      hi <= '0;
      mode <= M_OPEN;
      start_idx <= '0;
      end_idx <= '0;
      wp_status <= S_LOCK;
      busy <= 1'b0;
      done <= 1'b0;
      int_flag <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wr_en) begin
        st[idx] <= tgt;
        wp_status <= tgt;
      end
      if (busy) begin
        if (err_hit) cmd_err <= 1'b1;
        if (fin) begin
          busy <= 1'b0;
          done <= 1'b1;
          int_flag <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (reg_we) begin
        case (reg_sel)
          2'd0: begin
            start_idx <= reg_wdata[AW-1:0];
            end_idx <= reg_wdata[AW-1:0];
          end
          2'd1: end_idx <= reg_wdata[AW-1:0];
          2'd2: if (known) begin
            busy <= 1'b1;
            idx <= (code == C_ALL) ? '0 : start_idx;
            hi <= (code == C_ALL) ? AW'(NBLK - 1) : end_idx;
            mode <= (code == C_LOCK) ? M_LOCK : (code == C_TIGHT) ? M_TIGHT : M_OPEN;
          end
          default: begin
            int_flag <= 1'b0;
            cmd_err <= 1'b0;
          end
        endcase
      end
    end
  end

  // R1: the queried state of a real block is always a single one-hot code
  p_onehot_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(q_blk) < NBLK) |-> $onehot(q_state));

  // R9: status always carries a legal code
  p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wp_status));

  // R4: a tight block never leaves that state
  p_tight_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(q_blk) && $past(q_state) == S_TIGHT) |-> q_state == S_TIGHT);

  // R10: completion pulse ends the sweep and raises the interrupt
  p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && int_flag));

  // R2: a start write mirrors into the end index
  p_start_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_sel == 2'd0 && !busy) |-> end_idx == start_idx);

  // R11: writes during a sweep leave the index registers alone
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> ($stable(start_idx) && $stable(end_idx)));

  // R12: out-of-range queries read as zero
  p_query_oob_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(q_blk) >= NBLK) |-> q_state == 3'b000);
endmodule

// File: tb/wp_lock_mgr_bench.sv
module wp_lock_mgr_bench;
  localparam int N = 12;
  localparam int AW = 4;
  localparam int TIGHT = 1, LOCK = 2, OPEN = 4;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [AW-1:0] q_blk = 0;
  logic [2:0] q_state, wp_status;
  logic [AW-1:0] start_idx, end_idx;
  logic busy, done, int_flag, cmd_err;

  wp_lock_mgr #(.NBLK(N), .DW(16)) u_wp_lock_mgr (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .q_blk, .q_state,
    .start_idx, .end_idx, .wp_status, .busy, .done, .int_flag, .cmd_err);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int ex[N];
  int es, ee, estat, eerr, eiter;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) ex[i] = LOCK;
    es = 0; ee = 0; estat = LOCK; eerr = 0;
  endtask

  task automatic set_rng(input int s, input int e);
    wr(0, 16'(s)); es = s & 15; ee = es;
    wr(1, 16'(e)); ee = e & 15;
  endtask

  task automatic model(input int code);
    int lo, h, m, t, i;
    lo = (code == 8'h12) ? 0 : es;
    h = (code == 8'h12) ? N - 1 : ee;
    m = (code == 8'h21) ? LOCK : (code == 8'h31) ? TIGHT : OPEN;
    eiter = 0;
    i = lo;
    if (i > h) eiter = 1;
    else forever begin
      eiter++;
      if (i >= N) begin eerr = 1; break; end
      if (m != TIGHT && ex[i] == TIGHT) break;
      if (!(m == TIGHT && ex[i] == OPEN)) begin ex[i] = m; estat = m; end
      if (i == h) break;
      i++;
    end
    t = 0;
  endtask

  task automatic check_map(input string req);
    int bad, act, exp;
    bad = 0; act = 0; exp = 0;
    for (int b = 0; b < 16; b++) begin
      q_blk = 4'(b);
      #1;
      if (b < N && int'(q_state) != ex[b] && !bad) begin bad = 1; act = q_state; exp = ex[b]; end
      if (b >= N && q_state != 0 && !bad) begin bad = 1; act = q_state; exp = 0; end
    end
    chk(!bad, req, act, exp);
  endtask

  task automatic run(input int code, input string req);
    int cnt;
    model(code);
    wr(2, 16'(code));
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(done == 1, "R10 done pulse", done, 1);
    chk(int_flag == 1, "R10 int set", int_flag, 1);
    chk(cnt == eiter, {req, " busy cycles"}, cnt, eiter);
    chk(int'(cmd_err) == eerr, "R7 cmd_err", cmd_err, eerr);
    chk(int'(wp_status) == estat, "R9 status", wp_status, estat);
    check_map(req);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(!busy && !done && !int_flag && !cmd_err, "R1 flags idle", {busy, done, int_flag, cmd_err}, 0);
    chk(wp_status == 3'b010, "R1 status", wp_status, 2);
    check_map("R1 all locked");
    check_map("R12 query");

    // R2 masking and mirroring
    wr(0, 16'h1234);
    chk(start_idx == 4 && end_idx == 4, "R2 start mirror", end_idx, 4);
    wr(1, 16'h00f9);
    chk(start_idx == 4 && end_idx == 9, "R2 end override", end_idx, 9);

    // R3 R7 R8 sweep over every start/end pair
    for (int s = 0; s < 16; s++)
      for (int e = 0; e < 16; e++) begin
        set_rng(s, e);
        run(((s + e) % 2) ? 8'h21 : 8'h11, (s > e) ? "R8 empty range" : "R3 range");
        wr(3, 0); eerr = 0;
        chk(!int_flag && !cmd_err, "R10 clear", {int_flag, cmd_err}, 0);
      end

    // R4 R5 R6 tight sweeps over a mixed map
    for (int s = 0; s < 16; s++)
      for (int e = 0; e < 16; e++) begin
        do_reset();
        set_rng(3, 6);
        run(8'h11, "R3 open");
        set_rng(s, e);
        run(8'h31, "R5 tight");
        run(8'h12, "R6 open all");
        set_rng(0, 11);
        run(8'h21, "R4 lock stops");
      end

    // R11 writes during a sweep are ignored
    do_reset();
    wr(3, 0);
    set_rng(0, 11);
    model(8'h11);
    wr(2, 16'h11);
    reg_we = 1; reg_sel = 0; reg_wdata = 16'h5;
    @(negedge clk);
    reg_we = 0;
    while (busy) @(negedge clk);
    chk(start_idx == 0 && end_idx == 11, "R11 busy write ignored", start_idx, 0);
    check_map("R11 map after busy write");

    // R11 unknown code
    wr(3, 0);
    wr(2, 16'h55);
    chk(!busy && !int_flag, "R11 unknown code", {busy, int_flag}, 0);
    check_map("R11 unknown map");

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule